// File: doc/BRIEF.md
# Packed Byte Absolute-Difference Summer

This execution unit takes two 32-bit operands, each packing four unsigned 8-bit values, and returns the sum of the absolute differences of the byte pairs that share a lane position. It is the inner kernel of block-matching motion estimation: a search loop issues one operation per cycle, and each result comes back two cycles later carrying the destination tag that went in with it.

The pipeline has two register stages. The first stage holds the four lane differences and the second holds their sum. Valid and tag are delayed alongside the data. The unit never stalls. It accepts a new operation on every cycle that the issue-valid input is high.

Top module: `sad4_unit`

## Requirements
- R1: Lane k of each operand is bits [8k+7:8k], for k = 0..3. Each lane is unsigned. The result is the sum over k of |op_a lane k − op_b lane k|.
- R2: A result appears exactly 2 clock cycles after it is issued. res_valid is high in the cycle that is 2 cycles after a cycle with iss_valid high, and res_valid is low otherwise.
- R3: res_tag equals the iss_tag that was issued with the same operation, 2 cycles earlier.
- R4: Back-to-back issue on every cycle produces one correct result per cycle, and results come out in issue order.
- R5: The result is zero-extended to 32 bits. The largest possible value is 1020, so bits [31:10] are always zero.
- R6: A difference is never read as signed. For example, lanes 0x00 and 0xFF give 255, in either operand order.
- R7: While rst_n is low, res_valid is low. After reset is released, res_valid stays low until an operation has been issued.
- R8: When res_valid is low, res_data and res_tag hold the values of the last valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Operation issued this cycle |
| iss_tag | input | TAG_W | Destination tag carried with the operation |
| op_a | input | 32 | First packed operand |
| op_b | input | 32 | Second packed operand |
| res_valid | output | 1 | Result valid |
| res_tag | output | TAG_W | Tag of the returning result |
| res_data | output | 32 | Zero-extended sum of absolute differences |

## Verification
The hardest case to reach from the ports is a difference that wraps. A lane whose absolute difference crosses the signed midpoint would give the wrong result if the difference were read as signed. The bench reaches these cases by sweeping every pair of values in one lane exhaustively while the other lanes are held at mixed values. Bubbles are placed in the issue stream so that the hold behaviour of the outputs is exercised between the back-to-back bursts.

// File: rtl/sad4_pkg.sv
package sad4_pkg;
  localparam int LANE_W  = 8;
  localparam int LANES   = 4;
  localparam int WORD_W  = LANE_W * LANES;
  localparam int SUM_W   = LANE_W + $clog2(LANES);
  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [SUM_W-1:0]  sum_t;
endpackage

// File: rtl/sad4_lane_diff.sv
module sad4_lane_diff
  import sad4_pkg::*;
(
  input  lane_t a_i,
  input  lane_t b_i,
  output lane_t d_o
);
  always_comb begin
    if (a_i >= b_i) d_o = a_i - b_i;
    else            d_o = b_i - a_i;
  end
endmodule

// File: rtl/sad4_adder_tree.sv
module sad4_adder_tree
  import sad4_pkg::*;
(
  input  lane_t [LANES-1:0] d_i,
  output sum_t              s_o
);
  always_comb begin
    s_o = '0;
    for (int k = 0; k < LANES; k++) s_o = s_o + sum_t'(d_i[k]);
  end
endmodule

// File: rtl/sad4_unit.sv
module sad4_unit
  import sad4_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic [TAG_W-1:0] iss_tag,
  input  logic [31:0]      op_a,
  input  logic [31:0]      op_b,
  output logic             res_valid,
  output logic [TAG_W-1:0] res_tag,
  output logic [31:0]      res_data
);
  localparam int PAD_W = 32 - SUM_W;

  lane_t [LANES-1:0] diff_c, s1_diff_q, s1_diff_d;
  logic              s1_vld_q, s2_vld_q;
  logic [TAG_W-1:0]  s1_tag_q, s1_tag_d, s2_tag_q, s2_tag_d;
  sum_t              sum_c, s2_sum_q, s2_sum_d;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    sad4_lane_diff u_diff (
      .a_i (op_a[k*LANE_W +: LANE_W]),
      .b_i (op_b[k*LANE_W +: LANE_W]),
      .d_o (diff_c[k])
    );
  end

  sad4_adder_tree u_tree (.d_i(s1_diff_q), .s_o(sum_c));

  always_comb begin
    s1_diff_d = s1_diff_q;
    s1_tag_d  = s1_tag_q;
    if (iss_valid) begin
      s1_diff_d = diff_c;
      s1_tag_d  = iss_tag;
    end
    s2_sum_d = s2_sum_q;
    s2_tag_d = s2_tag_q;
    if (s1_vld_q) begin
      s2_sum_d = sum_c;
      s2_tag_d = s1_tag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      s2_vld_q <= 1'b0;
    end else begin
      s1_vld_q <= iss_valid;
      s2_vld_q <= s1_vld_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_diff_q <= '0;
      s1_tag_q  <= '0;
      s2_sum_q  <= '0;
      s2_tag_q  <= '0;
    end else begin
      s1_diff_q <= s1_diff_d;
      s1_tag_q  <= s1_tag_d;
      s2_sum_q  <= s2_sum_d;
      s2_tag_q  <= s2_tag_d;
    end
  end

  assign res_valid = s2_vld_q;
  assign res_tag   = s2_tag_q;
  assign res_data  = {{PAD_W{1'b0}}, s2_sum_q};

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld_q |=> res_valid);  // R2
  AST_TAG_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld_q |=> res_tag == $past(s1_tag_q));  // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    res_data <= 32'd1020);  // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld_q |=> $stable(res_data) && $stable(res_tag));  // R8
  AST_LANE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_data <= 32'd1020);  // R1
endmodule

// File: tb/sad4_unit_test.sv
module sad4_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic [TAG_W-1:0] iss_tag = '0;
  logic [31:0] op_a = '0, op_b = '0;
  logic res_valid;
  logic [TAG_W-1:0] res_tag;
  logic [31:0] res_data;

  int n_tests = 0, n_fail = 0;

  sad4_unit #(.TAG_W(TAG_W)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // model queue: expected result/tag per issued op, indexed by issue cycle
  logic [31:0] exp_d [0:3];
  logic [TAG_W-1:0] exp_t [0:3];
  logic exp_v [0:3];
  logic [31:0] last_d;
  logic [TAG_W-1:0] last_t;

  function automatic logic [31:0] ref_sad(input logic [31:0] a, input logic [31:0] b);
    int s = 0;
    for (int k = 0; k < 4; k++) begin
      int x = int'(a[k*8 +: 8]);
      int y = int'(b[k*8 +: 8]);
      s += (x > y) ? x - y : y - x;
    end
    return 32'(s);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drive one cycle; checks output at negedge after the edge
  task automatic step(input logic v, input logic [TAG_W-1:0] t,
                      input logic [31:0] a, input logic [31:0] b);
    iss_valid = v; iss_tag = t; op_a = a; op_b = b;
    @(posedge clk);
    for (int i = 3; i > 0; i--) begin
      exp_d[i] = exp_d[i-1]; exp_t[i] = exp_t[i-1]; exp_v[i] = exp_v[i-1];
    end
    exp_v[1] = v; exp_d[1] = ref_sad(a, b); exp_t[1] = t;
    @(negedge clk);
    if (exp_v[2]) begin
      chk("R1 data", res_data, exp_d[2]);
      chk("R3 tag", 32'(res_tag), 32'(exp_t[2]));
      chk("R5 upper zero", {10'd0, res_data[31:10]}, 32'd0);
      last_d = exp_d[2]; last_t = exp_t[2];
    end else begin
      chk("R8 hold data", res_data, last_d);
      chk("R8 hold tag", 32'(res_tag), 32'(last_t));
    end
    chk("R2 valid", 32'(res_valid), 32'(exp_v[2]));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin exp_v[i] = 0; exp_d[i] = 0; exp_t[i] = 0; end
    last_d = 0; last_t = 0;
    #(CLK_PERIOD * 2 + 1);
    chk("R7 reset valid", 32'(res_valid), 32'd0);
    chk("R7 reset data", res_data, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0);  // R7 idle stays low
    // R6 signed-wrap corners
    step(1, 1, 32'h00000000, 32'hFFFFFFFF);
    step(1, 2, 32'hFFFFFFFF, 32'h00000000);
    step(1, 3, 32'h7F80017F, 32'h807F7F81);
    step(0, 0, 0, 0); step(0, 0, 0, 0); step(0, 0, 0, 0);
    // R1 exhaustive lane-0 sweep, back-to-back with periodic bubbles (R4)
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++) begin
        logic [31:0] a = {8'(x ^ 8'h5A), 8'(y), 8'(x + 3), 8'(x)};
        logic [31:0] b = {8'(y), 8'(x), 8'(y * 7), 8'(y)};
        step(((x + y) % 13) != 0, TAG_W'(x * 3 + y), a, b);
      end
    // R1 sweep each upper lane alone
    for (int k = 1; k < 4; k++)
      for (int x = 0; x < 256; x += 5)
        for (int y = 0; y < 256; y += 3)
          step(1, TAG_W'(k + x), 32'(x) << (8*k), 32'(y) << (8*k));
    // R4 full-ones against zero: max 1020 alternating
    for (int i = 0; i < 8; i++)
      step(1, TAG_W'(i), (i % 2) ? 32'hFFFFFFFF : 32'h0, (i % 2) ? 32'h0 : 32'hFFFFFFFF);
    step(0, 0, 0, 0); step(0, 0, 0, 0); step(0, 0, 0, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule